// File: doc/BRIEF.md
# Multipurpose Pin Controller

This block manages four general-purpose pads. Each pad can be an input or an output. Software sets this through two 8-bit configuration registers. An output pad drives the level software chose and asserts its output enable. An input pad is left undriven. Its value passes through a synchroniser, is qualified by a per-pad polarity bit and is reported in a status vector.

Each input pad has two capture modes. In level mode its status bit follows the qualified pad value. In sticky mode the status bit latches any asserted sample. It is cleared by a status read strobe from the host side, unless the pad is still asserted in that same cycle. A reset or a bus suspend restores the power-on configuration: pads 0 to 2 become inputs, and pad 3 becomes an output driving high. All control and status pins are plain levels or strobes; there is no streamed data, so no valid/ready handshake exists.

Top module: `mpio_ctrl`

## Requirements
- R1: Register 0 holds pad 0 in bits 7:4 and pad 1 in bits 3:0; register 1 holds pad 2 in bits 7:4 and pad 3 in bits 3:0. Each nibble is, from its MSB down: direction, polarity, sensitivity, drive level. A write with `cfg_wr` high loads the addressed register at the clock edge, and `cfg_rdata` shows the register selected by `cfg_raddr` without delay.
- R2: Direction 1 makes a pad an output: `pin_oe` is 1 and `pin_out` equals the drive bit. Direction 0 gives `pin_oe` 0 and `pin_out` 0.
- R3: For an input pad, polarity 1 treats a high pad as asserted and polarity 0 treats a low pad as asserted.
- R4: With sensitivity 0 (level mode), the status bit of an input pad equals its asserted condition after synchronisation.
- R5: With sensitivity 1 (sticky mode), the status bit of an input pad becomes 1 after any asserted sample and holds 1 until a status read.
- R6: A `stat_rd` strobe leaves the status visible in that cycle unchanged and clears every sticky bit at the clock edge that ends the cycle.
- R7: If an input pad is asserted in the synchronised sample of the read cycle, its sticky bit stays 1 after the read.
- R8: The status bit of a pad configured as an output reads 0.
- R9: After synchronous reset (`rst_n` low at a clock edge), register 0 reads 8'h00 and register 1 reads 8'h09. `pin_oe` and `pin_out` are 4'b1000, and the sticky bits and synchroniser stages are 0.
- R10: While `suspend` is high, each clock edge restores the reset configuration and clears the sticky bits; a write in that cycle is ignored.
- R11: A pad change reaches a level-mode status bit after two clock edges and a sticky-mode status bit after three.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| suspend | input | 1 | Bus suspend; restores the default configuration |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_waddr | input | 1 | Register index for writes |
| cfg_wdata | input | 8 | Write data |
| cfg_raddr | input | 1 | Register index for readback |
| cfg_rdata | output | 8 | Readback data of the selected register |
| stat_rd | input | 1 | Status read strobe; clears the sticky bits |
| status | output | 4 | Per-pad status bits |
| pin_in | input | 4 | Pad input levels (asynchronous) |
| pin_out | output | 4 | Pad drive levels |
| pin_oe | output | 4 | Pad output enables |

## Verification
A corrupted configuration nibble shows at the ports within a cycle: it appears on `cfg_rdata`, `pin_oe` or `pin_out`, or it changes which source feeds `status`. A wrong synchroniser stage or sticky bit shows on `status` two or three edges after the pad stimulus. A missed clear or a lost event shows in the first cycle after a read strobe. A reference model in the bench, built from the requirements, runs in lockstep with the design and compares every output in every cycle. Random strobes, pad toggles, suspends and resets therefore expose any divergence in the cycle it appears.

// File: rtl/mpio_pkg.sv
package mpio_pkg;
  localparam int NIB_W  = 4;
  localparam int REG_W  = 8;
  localparam int PPR    = REG_W / NIB_W;

  typedef struct packed {
    logic dir;
    logic pol;
    logic sens;
    logic drv;
  } pin_cfg_t;
endpackage

// File: rtl/mpio_cfg_regs.sv
module mpio_cfg_regs
  import mpio_pkg::*;
#(
  parameter int           NPINS   = 4,
  parameter int           AW      = 1,
  parameter logic [NPINS-1:0] DEF_DIR = 4'b1000,
  parameter logic [NPINS-1:0] DEF_DRV = 4'b1000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   suspend,
  input  logic                   wr_en,
  input  logic [AW-1:0]          wr_addr,
  input  logic [REG_W-1:0]       wr_data,
  input  logic [AW-1:0]          rd_addr,
  output logic [REG_W-1:0]       rd_data,
  output logic [NPINS*NIB_W-1:0] cfg_flat
);
  localparam int NREGS = NPINS / PPR;

  function automatic logic [NPINS*NIB_W-1:0] defaults();
    logic [NPINS*NIB_W-1:0] v;
    v = '0;
    for (int p = 0; p < NPINS; p++)
      v[p*NIB_W +: NIB_W] = {DEF_DIR[p], 1'b0, 1'b0, DEF_DRV[p]};
    return v;
  endfunction

  logic [NPINS*NIB_W-1:0] cfg_q;

  always_ff @(posedge clk) begin
    if (!rst_n || suspend) begin
      cfg_q <= defaults();
    end else if (wr_en) begin
      for (int r = 0; r < NREGS; r++) begin
        if (wr_addr == AW'(r)) begin
          cfg_q[(PPR*r)*NIB_W   +: NIB_W] <= wr_data[REG_W-1 -: NIB_W];
          cfg_q[(PPR*r+1)*NIB_W +: NIB_W] <= wr_data[NIB_W-1:0];
        end
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int r = 0; r < NREGS; r++) begin
      if (rd_addr == AW'(r))
        rd_data = {cfg_q[(PPR*r)*NIB_W +: NIB_W], cfg_q[(PPR*r+1)*NIB_W +: NIB_W]};
    end
  end

  assign cfg_flat = cfg_q;
endmodule

// File: rtl/mpio_sync.sv
module mpio_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= '0;
    end else begin
      stg[0] <= d;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/mpio_capture.sv
module mpio_capture
  import mpio_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     suspend,
  input  pin_cfg_t cfg,
  input  logic     pin_s,
  input  logic     stat_rd,
  output logic     status
);
  logic asserted, armed, sticky_q;

  assign asserted = cfg.pol ? pin_s : ~pin_s;
  assign armed    = ~cfg.dir & cfg.sens;

  always_ff @(posedge clk) begin
    if (!rst_n || suspend) sticky_q <= 1'b0;
    else                   sticky_q <= armed & ((sticky_q & ~stat_rd) | asserted);
  end

  always_comb begin
    if (cfg.dir)       status = 1'b0;
    else if (cfg.sens) status = sticky_q;
    else               status = asserted;
  end
endmodule

// File: rtl/mpio_ctrl.sv
module mpio_ctrl
  import mpio_pkg::*;
#(
  parameter int               NPINS   = 4,
  parameter int               SYNC_N  = 2,
  parameter logic [NPINS-1:0] DEF_DIR = 4'b1000,
  parameter logic [NPINS-1:0] DEF_DRV = 4'b1000,
  localparam int              NREGS   = NPINS / PPR,
  localparam int              AW      = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             suspend,
  input  logic             cfg_wr,
  input  logic [AW-1:0]    cfg_waddr,
  input  logic [REG_W-1:0] cfg_wdata,
  input  logic [AW-1:0]    cfg_raddr,
  output logic [REG_W-1:0] cfg_rdata,
  input  logic             stat_rd,
  output logic [NPINS-1:0] status,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe
);
  logic [NPINS*NIB_W-1:0] cfg_flat;
  logic [NPINS-1:0]       pin_s;

  mpio_cfg_regs #(
    .NPINS(NPINS), .AW(AW), .DEF_DIR(DEF_DIR), .DEF_DRV(DEF_DRV)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .suspend(suspend),
    .wr_en(cfg_wr), .wr_addr(cfg_waddr), .wr_data(cfg_wdata),
    .rd_addr(cfg_raddr), .rd_data(cfg_rdata), .cfg_flat(cfg_flat)
  );

  mpio_sync #(.W(NPINS), .STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_s)
  );

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    pin_cfg_t pc;
    assign pc = pin_cfg_t'(cfg_flat[p*NIB_W +: NIB_W]);

    mpio_capture u_cap (
      .clk(clk), .rst_n(rst_n), .suspend(suspend), .cfg(pc),
      .pin_s(pin_s[p]), .stat_rd(stat_rd), .status(status[p])
    );

    assign pin_oe[p]  = pc.dir;
    assign pin_out[p] = pc.dir & pc.drv;
  end
endmodule

// File: rtl/mpio_ctrl_chk.sv
module mpio_ctrl_chk #(
  parameter int               NPINS   = 4,
  parameter int               AW      = 1,
  parameter logic [NPINS-1:0] DEF_DIR = 4'b1000,
  parameter logic [NPINS-1:0] DEF_DRV = 4'b1000
) (
  input logic               clk,
  input logic               rst_n,
  input logic               suspend,
  input logic               cfg_wr,
  input logic [AW-1:0]      cfg_waddr,
  input logic [7:0]         cfg_wdata,
  input logic               stat_rd,
  input logic [NPINS-1:0]   status,
  input logic [NPINS-1:0]   pin_oe,
  input logic [NPINS-1:0]   pin_out,
  input logic [NPINS*4-1:0] cfg_flat
);
  p_reset_dflt_r9: assert property (@(posedge clk)
    !rst_n |=> (pin_oe == DEF_DIR && pin_out == DEF_DRV));

  p_suspend_dflt_r10: assert property (@(posedge clk) disable iff (!rst_n)
    suspend |=> (pin_oe == DEF_DIR && pin_out == DEF_DRV));

  for (genvar i = 0; i < NPINS; i++) begin : g_chk
    localparam int DBIT = (i % 2 == 0) ? 7 : 3;
    localparam int OBIT = (i % 2 == 0) ? 4 : 0;

    p_wr_dir_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && !suspend && cfg_waddr == AW'(i/2))
        |=> (pin_oe[i] == $past(cfg_wdata[DBIT])));

    p_wr_drv_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && !suspend && cfg_waddr == AW'(i/2))
        |=> (pin_out[i] == ($past(cfg_wdata[DBIT]) & $past(cfg_wdata[OBIT]))));

    p_undriven_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !pin_oe[i] |-> !pin_out[i]);

    p_out_stat_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pin_oe[i] |-> !status[i]);

    p_sticky_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (status[i] && !cfg_flat[i*4+3] && cfg_flat[i*4+1] && !stat_rd && !suspend && !cfg_wr)
        |=> status[i]);
  end
endmodule

bind mpio_ctrl mpio_ctrl_chk #(
  .NPINS(NPINS), .AW(AW), .DEF_DIR(DEF_DIR), .DEF_DRV(DEF_DRV)
) u_chk (
  .clk(clk), .rst_n(rst_n), .suspend(suspend), .cfg_wr(cfg_wr),
  .cfg_waddr(cfg_waddr), .cfg_wdata(cfg_wdata), .stat_rd(stat_rd),
  .status(status), .pin_oe(pin_oe), .pin_out(pin_out), .cfg_flat(cfg_flat)
);

// File: tb/test_mpio_ctrl.sv
`timescale 1ns/1ps
module test_mpio_ctrl;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, suspend, cfg_wr, cfg_waddr, cfg_raddr, stat_rd;
  logic [7:0] cfg_wdata, cfg_rdata;
  logic [3:0] status, pin_in, pin_out, pin_oe;

  mpio_ctrl i_mpio_ctrl (
    .clk(clk), .rst_n(rst_n), .suspend(suspend), .cfg_wr(cfg_wr),
    .cfg_waddr(cfg_waddr), .cfg_wdata(cfg_wdata), .cfg_raddr(cfg_raddr),
    .cfg_rdata(cfg_rdata), .stat_rd(stat_rd), .status(status),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // reference state built from the requirements
  logic [3:0] m_dir, m_pol, m_sens, m_drv, m_s1, m_s2, m_stk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] m_reg(logic a);
    int b = a ? 2 : 0;
    return {m_dir[b], m_pol[b], m_sens[b], m_drv[b],
            m_dir[b+1], m_pol[b+1], m_sens[b+1], m_drv[b+1]};
  endfunction

  function automatic logic [3:0] m_true();
    return ~(m_s2 ^ m_pol);
  endfunction

  function automatic logic [3:0] m_status();
    logic [3:0] s;
    for (int i = 0; i < 4; i++)
      s[i] = m_dir[i] ? 1'b0 : (m_sens[i] ? m_stk[i] : m_true()[i]);
    return s;
  endfunction

  task automatic m_defaults();
    m_dir = 4'b1000; m_drv = 4'b1000; m_pol = '0; m_sens = '0;
  endtask

  task automatic model_edge();
    logic [3:0] nstk;
    if (!rst_n) begin
      m_defaults(); m_s1 = '0; m_s2 = '0; m_stk = '0;
    end else begin
      nstk = ~m_dir & m_sens & ((m_stk & ~{4{stat_rd}}) | m_true());
      m_s2 = m_s1; m_s1 = pin_in;
      if (suspend) begin
        m_defaults(); m_stk = '0;
      end else begin
        m_stk = nstk;
        if (cfg_wr) begin
          int b = cfg_waddr ? 2 : 0;
          {m_dir[b], m_pol[b], m_sens[b], m_drv[b]} = cfg_wdata[7:4];
          {m_dir[b+1], m_pol[b+1], m_sens[b+1], m_drv[b+1]} = cfg_wdata[3:0];
        end
      end
    end
  endtask

  task automatic compare_all();
    logic [3:0] es = m_status();
    for (int i = 0; i < 4; i++) begin
      if (m_dir[i])       check("R8 status of output pad", status[i], es[i]);
      else if (m_sens[i]) check("R5 sticky status", status[i], es[i]);
      else                check("R4 level status", status[i], es[i]);
    end
    check("R2 pin_oe", pin_oe, m_dir);
    check("R2 pin_out", pin_out, m_dir & m_drv);
    check("R1 readback", cfg_rdata, m_reg(cfg_raddr));
  endtask

  task automatic cyc();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle();
    cfg_wr = 0; stat_rd = 0; suspend = 0;
  endtask

  task automatic wr(logic a, logic [7:0] d);
    cfg_wr = 1; cfg_waddr = a; cfg_wdata = d; cyc(); cfg_wr = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; idle(); cfg_waddr = 0; cfg_wdata = 0; cfg_raddr = 0; pin_in = 4'b0000;
    m_defaults(); m_s1 = '0; m_s2 = '0; m_stk = '0;
    @(negedge clk);
    cyc(); cyc();
    rst_n = 1;
    // R9: reset defaults
    cfg_raddr = 0; #0.1 check("R9 reg0 default", cfg_rdata, 8'h00);
    cfg_raddr = 1; #0.1 check("R9 reg1 default", cfg_rdata, 8'h09);
    check("R9 pin_oe default", pin_oe, 4'b1000);
    check("R9 pin_out default", pin_out, 4'b1000);
    cyc();

    // R3/R11: pad0 high-true level, pad1 low-true level
    wr(0, 8'h40);
    cfg_raddr = 0; #0.1 check("R1 reg0 written", cfg_rdata, 8'h40);
    pin_in = 4'b0011; cyc();
    check("R11 level after one edge", status[0], 1'b0);
    cyc();
    check("R11 level after two edges", status[0], 1'b1);
    check("R3 low-true pad high", status[1], 1'b0);
    pin_in = 4'b0000; cyc(); cyc();
    check("R3 high-true pad low", status[0], 1'b0);
    check("R3 low-true pad low", status[1], 1'b1);

    // R5/R6/R11: pad0 sticky high-true, single-cycle pulse
    wr(0, 8'h60); cyc(); cyc();
    pin_in = 4'b0001; cyc(); pin_in = 4'b0000; cyc();
    check("R11 sticky before third edge", status[0], 1'b0);
    cyc();
    check("R11 sticky after third edge", status[0], 1'b1);
    for (int k = 0; k < 5; k++) cyc();
    check("R5 sticky holds", status[0], 1'b1);
    stat_rd = 1; #0.1
    check("R6 status visible in read cycle", status[0], 1'b1);
    cyc(); stat_rd = 0;
    check("R6 cleared after read", status[0], 1'b0);

    // R7: asserted during read keeps bit
    pin_in = 4'b0001; cyc(); cyc(); cyc();
    stat_rd = 1; cyc(); stat_rd = 0;
    check("R7 asserted at read keeps bit", status[0], 1'b1);
    pin_in = 4'b0000; cyc(); cyc();
    stat_rd = 1; cyc(); stat_rd = 0;
    check("R7 clears once deasserted", status[0], 1'b0);

    // R8/R2: pad0 as output driving high with pad high
    wr(0, 8'h90); pin_in = 4'b0001; cyc(); cyc(); cyc();
    check("R8 output pad status", status[0], 1'b0);
    check("R2 output pad drive", {pin_oe[0], pin_out[0]}, 2'b11);

    // R10: suspend restores defaults, concurrent write ignored
    wr(1, 8'h66); pin_in = 4'b1100; cyc(); cyc(); cyc();
    check("R10 sticky set before suspend", status[3:2], 2'b11);
    suspend = 1; cfg_wr = 1; cfg_waddr = 0; cfg_wdata = 8'hFF; cyc();
    idle();
    cfg_raddr = 0; #0.1 check("R10 reg0 after suspend", cfg_rdata, 8'h00);
    cfg_raddr = 1; #0.1 check("R10 reg1 after suspend", cfg_rdata, 8'h09);
    check("R10 pins after suspend", {pin_oe, pin_out}, 8'h88);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      cfg_wr    = ($urandom_range(99) < 10);
      cfg_waddr = $urandom_range(1);
      cfg_wdata = 8'($urandom);
      cfg_raddr = $urandom_range(1);
      stat_rd   = ($urandom_range(99) < 15);
      suspend   = ($urandom_range(99) < 2);
      rst_n     = !(n == 2000);
      for (int i = 0; i < 4; i++)
        if ($urandom_range(99) < 20) pin_in[i] = ~pin_in[i];
      cyc();
    end
    idle(); rst_n = 1; cyc();
    finish_run();
  end
endmodule